// File: doc/BRIEF.md
# Safety-Protected Control Register Bank

This block is a small bank of software-visible control registers. Each register can be hardened when the bank is elaborated. Four protections are available, and any mix of them, or none, can be chosen per register:

- an even parity bit per byte,
- a second copy that is compared continuously with the first,
- three copies feeding a bitwise majority vote,
- a shadow copy that the hardware reads, refreshed from the software copy only on a sync pulse.

Software reaches the bank through a plain word-addressed port. Writes use byte strobes. Reads return their data one cycle after the request.

The hardware side gets every register's value on a flat output bus. Whenever a protection sees a disagreement, it latches a sticky status bit for that register. The status bits are masked by an enable register and combined into one level interrupt. A fault-injection port flips chosen bits of any stored copy, so detection, comparison and voting can be exercised.

Top module: `safe_csr_bank`

## Requirements
- R1: Register i sits at word address i (0..NUM_REGS-1), the error status at NUM_REGS and the interrupt enable at NUM_REGS+1. After reset every copy of every register holds RST_VAL, status and enable read 0, and irq is low.
- R2: A write takes effect at the clock edge that samples wr_en, on the bytes whose wstrb bit is 1. A read sampled at one edge shows its data on rd_data after that same edge, and rd_data is 0 after an edge with no read.
- R3: Protection bit 0 adds even parity per byte of the primary copy. A flipped data bit or a flipped parity bit sets that register's status bit.
- R4: Bytes outside the strobes keep their old data and old parity, so a fault in such a byte stays flagged. A write with all strobes set leaves the register free of errors.
- R5: Protection bit 1 adds a second copy written with the first. Any difference between the copies sets the status bit, while reads and the hardware side show the primary copy.
- R6: Protection bit 2 keeps three copies. Reads and the hardware side see the bitwise majority, so a fault in one copy is hidden, yet the disagreement sets the status bit.
- R7: A write to a triple-copy register loads the merged value into all three copies, which clears the disagreement.
- R8: Protection bit 3 adds a shadow copy. hw_q shows only the shadow, and the shadow loads the software value only on sync_pulse. Software reads show the software copy.
- R9: When sync_pulse and a write to the same shadowed register share a cycle, the shadow takes the value from before the write.
- R10: Status bits are sticky and are cleared by writing 1 to them (strobes ignored). A still-present error in the same cycle wins over the clear.
- R11: irq is the OR of status AND enable, a level that follows the status register.
- R12: A register with no protection takes injected flips into its value without setting any status bit.
- R13: Combined protections each report: in a register with parity, a second copy and a shadow, a fault in either the second copy or the parity bits sets the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write request |
| rd_en | input | 1 | Software read request |
| addr | input | ADDR_W | Word address for read or write |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Byte write enables |
| rd_data | output | DATA_W | Read data, one cycle after rd_en |
| sync_pulse | input | 1 | Loads all shadow copies from the software copies |
| hw_q | output | NUM_REGS*DATA_W | Register values seen by hardware, register i at bits i*DATA_W |
| irq | output | 1 | Level interrupt |
| fi_en | input | 1 | Fault-injection strobe |
| fi_reg | input | ADDR_W | Register targeted by the injection |
| fi_copy | input | 3 | Copy targeted: 0 primary, 1 second, 2 third, 3 shadow, 4 parity bits |
| fi_mask | input | DATA_W | Bits to flip; for parity, the low DATA_W/8 bits |

## Verification
- **Writes, injections and sync:** a write, an injection or a sync pulse alters stored state at the edge that samples it. The bench therefore samples hw_q and the register values at the following falling edge.
- **Status and interrupt:** a status bit, and irq with it, rises one edge after the faulty copy appears. The bench leaves one idle cycle after every injection before it reads status or looks at irq.
- **Reads:** every read is captured at the falling edge after the edge that sampled rd_en. Expected values come from a bench-side model of the register contents and shadows, updated in the same cycle the stimulus is applied.

// File: rtl/safe_csr_pkg.sv
package safe_csr_pkg;

    // Protection selector: one nibble per register.
    localparam int unsigned PROT_W = 4;

    typedef struct packed {
        logic shd;  // bit 3: sync-loaded shadow copy
        logic tmr;  // bit 2: three copies with majority vote
        logic dup;  // bit 1: second copy with compare
        logic par;  // bit 0: even parity per byte
    } prot_t;

    typedef enum logic [2:0] {
        FI_PRIMARY = 3'd0,
        FI_SECOND  = 3'd1,
        FI_THIRD   = 3'd2,
        FI_SHADOW  = 3'd3,
        FI_PARITY  = 3'd4
    } fi_copy_e;

    function automatic logic byte_parity(input logic [7:0] b);
        return ^b;
    endfunction

    function automatic logic [7:0] maj_byte(input logic [7:0] a,
                                            input logic [7:0] b,
                                            input logic [7:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/safe_csr_cell.sv
module safe_csr_cell
    import safe_csr_pkg::*;
#(
    parameter int unsigned        DW      = 32,
    parameter logic [PROT_W-1:0]  PROT    = '0,
    parameter logic [DW-1:0]      RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/8-1:0] wstrb,
    input  logic            sync,
    input  logic            fi_en,
    input  logic [2:0]      fi_copy,
    input  logic [DW-1:0]   fi_mask,
    output logic [DW-1:0]   sw_q,
    output logic [DW-1:0]   hw_q,
    output logic            err
);
    localparam int unsigned NB      = DW / 8;
    localparam prot_t       P       = prot_t'(PROT);
    localparam bit          HAS_PAR = P.par;
    localparam bit          HAS_TMR = P.tmr;
    localparam bit          HAS_C2  = P.dup | P.tmr;
    localparam bit          HAS_SHD = P.shd;

    logic [DW-1:0] p_q, c2_q, c3_q, voted;
    logic [NB-1:0] par_q, par_calc, par_rst;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] nv,
                                            input logic [DW-1:0] ov,
                                            input logic [NB-1:0] st);
        logic [DW-1:0] r;
        for (int b = 0; b < NB; b++)
            r[8*b +: 8] = st[b] ? nv[8*b +: 8] : ov[8*b +: 8];
        return r;
    endfunction

    function automatic logic [DW-1:0] hit(input fi_copy_e which);
        return (fi_en && fi_copy == which) ? fi_mask : '0;
    endfunction

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            voted[8*b +: 8] = maj_byte(p_q[8*b +: 8], c2_q[8*b +: 8], c3_q[8*b +: 8]);
            par_calc[b]     = byte_parity(p_q[8*b +: 8]);
            par_rst[b]      = byte_parity(RST_VAL[8*b +: 8]);
        end
    end

    // With three copies every copy is refreshed from the vote.
    assign sw_q = HAS_TMR ? voted : p_q;

    always_ff @(posedge clk) begin
        if (rst)
            p_q <= RST_VAL;
        else
            p_q <= (we ? merge(wdata, HAS_TMR ? voted : p_q, wstrb) : p_q) ^ hit(FI_PRIMARY);
    end

    generate
        if (HAS_C2) begin : g_second
            always_ff @(posedge clk) begin
                if (rst)
                    c2_q <= RST_VAL;
                else
                    c2_q <= (we ? merge(wdata, HAS_TMR ? voted : c2_q, wstrb) : c2_q)
                            ^ hit(FI_SECOND);
            end
        end else begin : g_no_second
            assign c2_q = p_q;
        end

        if (HAS_TMR) begin : g_third
            always_ff @(posedge clk) begin
                if (rst)
                    c3_q <= RST_VAL;
                else
                    c3_q <= (we ? merge(wdata, voted, wstrb) : c3_q) ^ hit(FI_THIRD);
            end
            AST_TMR_MASKS_ONE: assert property (@(posedge clk) disable iff (rst)
                (c2_q == c3_q) |-> (sw_q == c2_q)); // R6
        end else begin : g_no_third
            assign c3_q = p_q;
        end

        if (HAS_PAR) begin : g_parity
            always_ff @(posedge clk) begin
                if (rst) begin
                    par_q <= par_rst;
                end else begin
                    for (int b = 0; b < NB; b++)
                        par_q[b] <= ((we && wstrb[b]) ? byte_parity(wdata[8*b +: 8]) : par_q[b])
                                    ^ (fi_en && fi_copy == FI_PARITY && fi_mask[b]);
                end
            end
        end else begin : g_no_parity
            assign par_q = par_calc;
        end

        if (HAS_SHD) begin : g_shadow
            logic [DW-1:0] s_q;
            always_ff @(posedge clk) begin
                if (rst)
                    s_q <= RST_VAL;
                else
                    s_q <= (sync ? sw_q : s_q) ^ hit(FI_SHADOW);
            end
            assign hw_q = s_q;
            AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (!sync && !(fi_en && fi_copy == FI_SHADOW)) |=> $stable(hw_q)); // R8
        end else begin : g_no_shadow
            logic unused_sync;
            assign unused_sync = sync;
            assign hw_q = sw_q;
        end
    endgenerate

    // Copies that do not exist are tied to the primary and never disagree.
    assign err = (par_q != par_calc) | (p_q != c2_q) | (c2_q != c3_q);

    AST_FULL_WRITE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (we && (&wstrb) && !fi_en) |=> !err); // R4

endmodule

// File: rtl/safe_csr_status.sv
module safe_csr_status #(
    parameter int unsigned NR = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NR-1:0] err_in,
    input  logic          stat_we,
    input  logic          ien_we,
    input  logic [NR-1:0] wdata,
    output logic [NR-1:0] stat_q,
    output logic [NR-1:0] ien_q,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            ien_q  <= '0;
        end else begin
            // A live error outranks a clear in the same cycle.
            stat_q <= (stat_q & ~(stat_we ? wdata : '0)) | err_in;
            if (ien_we)
                ien_q <= wdata;
        end
    end

    assign irq = |(stat_q & ien_q);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $fell(rst) |-> (stat_q == '0 && !irq)); // R1

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (|(err_in & ien_q) && !ien_we) |=> irq); // R11

    generate
        for (genvar i = 0; i < NR; i++) begin : g_bit
            AST_STICKY_BIT: assert property (@(posedge clk) disable iff (rst)
                (stat_q[i] && !(stat_we && wdata[i])) |=> stat_q[i]); // R10
            AST_ERROR_SETS: assert property (@(posedge clk) disable iff (rst)
                err_in[i] |=> stat_q[i]); // R10
        end
    endgenerate

endmodule

// File: rtl/safe_csr_rdmux.sv
module safe_csr_rdmux #(
    parameter int unsigned NR     = 6,
    parameter int unsigned DW     = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NR*DW-1:0] sw_flat,
    input  logic [NR-1:0]    stat_q,
    input  logic [NR-1:0]    ien_q,
    output logic [DW-1:0]    rd_data
);
    localparam int unsigned ADDR_STAT = NR;
    localparam int unsigned ADDR_IEN  = NR + 1;

    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NR; i++)
            if (addr == ADDR_W'(i))
                sel = sw_flat[i*DW +: DW];
        if (addr == ADDR_W'(ADDR_STAT))
            sel = DW'(stat_q);
        if (addr == ADDR_W'(ADDR_IEN))
            sel = DW'(ien_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= rd_en ? sel : '0;
    end

endmodule

// File: rtl/safe_csr_bank.sv
module safe_csr_bank
    import safe_csr_pkg::*;
#(
    parameter int unsigned                NUM_REGS = 6,
    parameter int unsigned                DATA_W   = 32,
    parameter logic [NUM_REGS*PROT_W-1:0] PROT_MAP = {4'hC, 4'hB, 4'h4, 4'h2, 4'h1, 4'h0},
    parameter logic [DATA_W-1:0]          RST_VAL  = 32'h0000_00A5,
    localparam int unsigned               NB       = DATA_W / 8,
    localparam int unsigned               ADDR_W   = $clog2(NUM_REGS + 2)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NB-1:0]              wstrb,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       sync_pulse,
    output logic [NUM_REGS*DATA_W-1:0] hw_q,
    output logic                       irq,
    input  logic                       fi_en,
    input  logic [ADDR_W-1:0]          fi_reg,
    input  logic [2:0]                 fi_copy,
    input  logic [DATA_W-1:0]          fi_mask
);
    localparam int unsigned ADDR_STAT = NUM_REGS;
    localparam int unsigned ADDR_IEN  = NUM_REGS + 1;

    logic [NUM_REGS*DATA_W-1:0] sw_flat;
    logic [NUM_REGS-1:0]        err_vec, stat_q, ien_q;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            safe_csr_cell #(
                .DW      (DATA_W),
                .PROT    (PROT_MAP[i*PROT_W +: PROT_W]),
                .RST_VAL (RST_VAL)
            ) u_cell (
                .clk     (clk),
                .rst     (rst),
                .we      (wr_en && addr == ADDR_W'(i)),
                .wdata   (wdata),
                .wstrb   (wstrb),
                .sync    (sync_pulse),
                .fi_en   (fi_en && fi_reg == ADDR_W'(i)),
                .fi_copy (fi_copy),
                .fi_mask (fi_mask),
                .sw_q    (sw_flat[i*DATA_W +: DATA_W]),
                .hw_q    (hw_q[i*DATA_W +: DATA_W]),
                .err     (err_vec[i])
            );
        end
    endgenerate

    safe_csr_status #(.NR(NUM_REGS)) u_status (
        .clk     (clk),
        .rst     (rst),
        .err_in  (err_vec),
        .stat_we (wr_en && addr == ADDR_W'(ADDR_STAT)),
        .ien_we  (wr_en && addr == ADDR_W'(ADDR_IEN)),
        .wdata   (wdata[NUM_REGS-1:0]),
        .stat_q  (stat_q),
        .ien_q   (ien_q),
        .irq     (irq)
    );

    safe_csr_rdmux #(.NR(NUM_REGS), .DW(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (addr),
        .sw_flat (sw_flat),
        .stat_q  (stat_q),
        .ien_q   (ien_q),
        .rd_data (rd_data)
    );

    AST_RD_IEN_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(ADDR_IEN)) |=> (rd_data == DATA_W'($past(ien_q)))); // R2

endmodule

// File: tb/safe_csr_bank_tb.sv
`timescale 1ns/100ps
module safe_csr_bank_tb;
    localparam int NR = 6, DW = 32, AW = 3;
    localparam int ST = 6, IE = 7;
    localparam logic [31:0] RSTV = 32'h0000_00A5;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 0, rd_en = 0, sync_pulse = 0, fi_en = 0, irq;
    logic [AW-1:0] addr = '0, fi_reg = '0;
    logic [31:0] wdata = '0, rd_data, fi_mask = '0;
    logic [3:0] wstrb = '0;
    logic [2:0] fi_copy = '0;
    logic [NR*DW-1:0] hw_q;

    always #2.5 clk = ~clk;

    safe_csr_bank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .rd_data(rd_data), .sync_pulse(sync_pulse),
        .hw_q(hw_q), .irq(irq), .fi_en(fi_en), .fi_reg(fi_reg),
        .fi_copy(fi_copy), .fi_mask(fi_mask)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] m_val [NR];
    logic [31:0] m_shd [NR];
    logic [31:0] rdq;

    function automatic bit is_shd(input int i);
        return (i == 4) || (i == 5);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] n, input logic [31:0] o,
                                          input logic [3:0] s);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = s[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One cycle of software activity; model follows the requirements.
    task automatic op(input bit w, input bit r, input int a, input logic [31:0] d,
                      input logic [3:0] s, input bit sy);
        wr_en = w; rd_en = r; addr = AW'(a); wdata = d; wstrb = s; sync_pulse = sy;
        if (sy) for (int i = 0; i < NR; i++) if (is_shd(i)) m_shd[i] = m_val[i];
        if (w && a < NR) m_val[a] = merge(d, m_val[a], s);
        tick();
        rdq = rd_data;
        wr_en = 0; rd_en = 0; sync_pulse = 0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        op(0, 1, a, '0, '0, 0);
        chk(req, rdq, exp);
    endtask

    task automatic hw_chk(input string req);
        for (int i = 0; i < NR; i++)
            chk(req, hw_q[i*DW +: DW], is_shd(i) ? m_shd[i] : m_val[i]);
    endtask

    task automatic inject(input int r, input int c, input logic [31:0] m);
        fi_en = 1; fi_reg = AW'(r); fi_copy = 3'(c); fi_mask = m;
        if (c == 0) m_val[r] = m_val[r] ^ m;
        tick();
        fi_en = 0;
        tick();
    endtask

    task automatic repair_clear(input int r);
        op(1, 0, r, $urandom, 4'hF, 0);
        op(1, 0, ST, 32'hFFFF_FFFF, 4'h0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NR; i++) begin m_val[i] = RSTV; m_shd[i] = RSTV; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 0);
        hw_chk("R1 hw");
        for (int a = 0; a < NR; a++) rd_chk("R1 reg", a, RSTV);
        rd_chk("R1 status", ST, 0);
        rd_chk("R1 enable", IE, 0);
        chk("R2 idle rd", rd_data, 0);

        // R2 / R8: random traffic without faults
        for (int k = 0; k < 400; k++) begin
            int kind = int'($urandom % 4);
            int a = int'($urandom % NR);
            case (kind)
                0: op(1, 0, a, $urandom, 4'($urandom), ($urandom % 3) == 0);
                1: begin
                    logic [31:0] e = m_val[a];
                    op(0, 1, a, '0, '0, 0);
                    chk("R2 read", rdq, e);
                end
                2: op(0, 0, 0, '0, '0, 1);
                default: op(0, 0, 0, '0, '0, 0);
            endcase
            hw_chk("R8 hw");
        end
        rd_chk("R2 status clean", ST, 0);

        // R3, R4, R10: parity register 1
        inject(1, 0, 32'h0000_0200);
        rd_chk("R3 data flip", ST, 32'h2);
        rd_chk("R3 value", 1, m_val[1]);
        op(1, 0, 1, 32'h1234_5678, 4'b0001, 0);
        op(1, 0, ST, 32'h2, 4'hF, 0);
        rd_chk("R4 unstrobed byte stays bad", ST, 32'h2);
        rd_chk("R4 merged value", 1, m_val[1]);
        repair_clear(1);
        rd_chk("R4 full write repairs", ST, 0);
        inject(1, 4, 32'h4);
        rd_chk("R3 parity flip", ST, 32'h2);
        rd_chk("R3 value kept", 1, m_val[1]);
        repair_clear(1);
        rd_chk("R3 clear", ST, 0);

        // R5: duplicate register 2
        inject(2, 1, 32'h8000_0001);
        rd_chk("R5 mismatch", ST, 32'h4);
        rd_chk("R5 primary read", 2, m_val[2]);
        hw_chk("R5 hw");
        repair_clear(2);
        rd_chk("R5 repaired", ST, 0);

        // R6, R7: triple register 3
        inject(3, 2, 32'hFFFF_FFFF);
        hw_chk("R6 masked hw");
        rd_chk("R6 masked read", 3, m_val[3]);
        rd_chk("R6 flagged", ST, 32'h8);
        op(1, 0, 3, 32'hCAFE_00EE, 4'b0001, 0);
        op(1, 0, ST, 32'h8, 4'h0, 0);
        rd_chk("R7 refresh", ST, 0);
        rd_chk("R7 value", 3, m_val[3]);
        inject(3, 0, 32'h00FF_0000);
        rd_chk("R6 primary masked", 3, m_val[3] ^ 32'h00FF_0000);
        m_val[3] = m_val[3] ^ 32'h00FF_0000;
        repair_clear(3);

        // R8, R9: shadow register 4
        op(1, 0, 4, 32'hAAAA_5555, 4'hF, 0);
        chk("R8 hw holds", hw_q[4*DW +: DW], m_shd[4]);
        rd_chk("R8 sw copy", 4, 32'hAAAA_5555);
        op(0, 0, 0, '0, '0, 1);
        chk("R8 after sync", hw_q[4*DW +: DW], 32'hAAAA_5555);
        op(1, 0, 4, 32'h0F0F_0F0F, 4'hF, 1);
        chk("R9 old value", hw_q[4*DW +: DW], 32'hAAAA_5555);
        op(0, 0, 0, '0, '0, 1);
        chk("R9 next sync", hw_q[4*DW +: DW], 32'h0F0F_0F0F);
        hw_chk("R8 all");

        // R13: combined protections on register 4
        inject(4, 1, 32'h10);
        rd_chk("R13 second copy", ST, 32'h10);
        repair_clear(4);
        rd_chk("R13 clear", ST, 0);
        inject(4, 4, 32'h1);
        rd_chk("R13 parity", ST, 32'h10);
        repair_clear(4);
        rd_chk("R13 clear2", ST, 0);

        // R10, R11: interrupt and stickiness
        op(1, 0, IE, 32'h4, 4'hF, 0);
        rd_chk("R11 enable", IE, 32'h4);
        inject(1, 0, 32'h1);
        chk("R11 masked", {31'b0, irq}, 0);
        inject(2, 1, 32'h2);
        chk("R11 raised", {31'b0, irq}, 1);
        rd_chk("R11 status", ST, 32'h6);
        repair_clear(2);
        m_val[1] = m_val[1] ^ 32'h0; // register 1 still faulty
        chk("R11 dropped", {31'b0, irq}, 0);
        rd_chk("R10 live error kept", ST, 32'h2);
        inject(1, 0, 32'h1);
        op(0, 0, 0, '0, '0, 0);
        rd_chk("R10 sticky", ST, 32'h2);
        op(1, 0, ST, 32'h2, 4'h0, 0);
        rd_chk("R10 cleared", ST, 0);

        // R12: unprotected register 0
        inject(0, 0, 32'h0000_0F00);
        rd_chk("R12 no flag", ST, 0);
        rd_chk("R12 value", 0, m_val[0]);
        hw_chk("R12 hw");
        chk("R12 irq", {31'b0, irq}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule